// File: doc/BRIEF.md
# Chained-Block DMA Controller

This block copies data between a peripheral and memory without the processor taking part. Software sets a base address, a byte length and a direction in a small register set, then writes a start command. The controller then drives the memory address, read and write strobes and write data itself. It trades words with the peripheral over a request/acknowledge handshake, one word per handshake. At the end it raises a sticky done flag and an interrupt.

In chain mode the base register points to a list of descriptors in memory instead of to the data. Each descriptor is four words: data address, byte length, flags and a link to the next descriptor. A buffer that is scattered over physical pages can therefore be moved as one job. Every block must fit inside one page. A block that is empty or that would run past its page stops the job and sets an error flag.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, busy, done, error and interrupt read as 0. The base, length and mode registers read 0. The memory strobes and the peripheral acknowledge are low.
- R2: Register map, by cfg_addr. Offset 0 is the base address. Offset 1 is the length in bytes; the low two bits are ignored when words are counted. Offset 2 is the mode: bit 0 selects the direction (1 = memory to peripheral, 0 = peripheral to memory) and bit 1 selects chain mode. Offset 3 reads status (bit 0 busy, bit 1 done, bit 2 error). A write to offset 3 with bit 0 set starts a job, and a write with bit 1 set clears done and error. Offsets 0 to 2 read back what was written.
- R3: Peripheral to memory: the block asserts per_ack only while per_req is high. Each cycle with both high moves one per_rdata word. The words are written to memory at consecutive addresses, starting at the block address and rising by 4, and nothing is written past the block.
- R4: Memory to peripheral: the words of the block are read in address order. Each one is presented on per_wdata in the cycle its handshake completes, and memory is left unchanged.
- R5: In chain mode the base register holds the address of the first descriptor, and the length register and the mode direction bit have no effect. A descriptor is four words: +0 data address, +4 byte length, +8 flags (bit 0 = direction, same encoding as mode bit 0), +12 next descriptor address. A next address of 0 ends the chain. Blocks run in list order and may mix directions.
- R6: A block is rejected when it holds zero words, or when its in-page offset plus its length in bytes exceeds the page size. A rejected block ends the job with the error flag set and the done flag clear. It moves no data, but blocks that ran before it keep their effect. A block that ends exactly on the page end is accepted.
- R7: When the last block completes, done is set and irq is raised. Both stay high until software clears them or starts a new job.
- R8: Busy is high from the start write until the job completes or stops on an error. While busy, writes to offsets 0 to 2 and further start commands are ignored, and no memory strobe or acknowledge occurs while idle.
- R9: The clear command and an accepted start each reset the done and error flags.
- R10: The memory read and write strobes are never high together, and every memory access uses a word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after mem_rd |
| per_req | input | 1 | Peripheral ready to supply or accept a word |
| per_ack | output | 1 | Word accepted or supplied in this cycle |
| per_rdata | input | 32 | Word from the peripheral |
| per_wdata | output | 32 | Word to the peripheral |
| irq | output | 1 | Completion interrupt, follows the done flag |

## Verification
The assertions assume that memory returns read data exactly one cycle after a read strobe. They also assume that the peripheral holds per_rdata valid whenever it raises per_req, and that software writes registers only through the cfg port. The bench memory model has a fixed one-cycle read latency. Every address it drives stays inside the modelled memory. The peripheral model derives its data from its own handshake count and only throttles per_req at clock edges. This keeps the stimulus within those assumptions while the bench still covers stalls, page-end boundaries and rejected blocks.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int WORD_W = 32;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_LEN  = 2'd1;
  localparam logic [1:0] REG_MODE = 2'd2;
  localparam logic [1:0] REG_CMD  = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DESC_RD,
    ST_DESC_CAP,
    ST_CHECK,
    ST_D2M_WAIT,
    ST_D2M_WR,
    ST_M2D_RD,
    ST_M2D_CAP,
    ST_M2D_WAIT
  } eng_state_t;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic              err_set,
  output logic [ADDR_W-1:0] base_q,
  output logic [WORD_W-1:0] len_q,
  output logic              dir_q,
  output logic              chain_q,
  output logic              start_go,
  output logic              done_q,
  output logic              err_q
);
  logic wr_base, wr_len, wr_mode, clr_cmd;
  logic done_d, err_d, flag_en;

  always_comb begin
    wr_base  = cfg_we && (cfg_addr == REG_BASE) && !busy;
    wr_len   = cfg_we && (cfg_addr == REG_LEN)  && !busy;
    wr_mode  = cfg_we && (cfg_addr == REG_MODE) && !busy;
    start_go = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[0] && !busy;
    clr_cmd  = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[1];

    done_d = done_q;
    err_d  = err_q;
    if (clr_cmd || start_go) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (done_set) done_d = 1'b1;
    if (err_set)  err_d  = 1'b1;
    flag_en = clr_cmd || start_go || done_set || err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      dir_q   <= 1'b0;
      chain_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_base) base_q <= cfg_wdata[ADDR_W-1:0];
      if (wr_len)  len_q  <= cfg_wdata;
      if (wr_mode) begin
        dir_q   <= cfg_wdata[0];
        chain_q <= cfg_wdata[1];
      end
      if (flag_en) begin
        done_q <= done_d;
        err_q  <= err_d;
      end
    end
  end

  always_comb begin
    unique case (cfg_addr)
      REG_BASE: cfg_rdata = WORD_W'(base_q);
      REG_LEN:  cfg_rdata = len_q;
      REG_MODE: cfg_rdata = {{(WORD_W-2){1'b0}}, chain_q, dir_q};
      default:  cfg_rdata = {{(WORD_W-3){1'b0}}, err_q, done_q, busy};
    endcase
  end
endmodule

// File: rtl/dma_page_check.sv
module dma_page_check #(
  parameter int LEN_W   = 16,
  parameter int PAGE_LG = 12
) (
  input  logic [PAGE_LG-1:0] blk_off,
  input  logic [29:0]        blk_wlen,
  output logic [LEN_W-3:0]   blk_words,
  output logic               blk_bad
);
  localparam int WCNT_W = LEN_W - 2;
  localparam int SUM_W  = ((LEN_W > PAGE_LG) ? LEN_W : PAGE_LG) + 1;
  localparam logic [SUM_W-1:0] PAGE_SZ = SUM_W'(1) << PAGE_LG;

  logic             too_big;
  logic [SUM_W-1:0] span;

  always_comb begin
    too_big   = |blk_wlen[29:WCNT_W];
    blk_words = blk_wlen[WCNT_W-1:0];
    span      = SUM_W'(blk_off) + SUM_W'({blk_words, 2'b00});
    blk_bad   = too_big || (blk_words == '0) || (span > PAGE_SZ);
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int PAGE_LG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [29:0]       cfg_wlen,
  input  logic              cfg_dir,
  input  logic              cfg_chain,
  output logic [PAGE_LG-1:0] blk_off,
  output logic [29:0]       blk_wlen,
  input  logic [LEN_W-3:0]  blk_words,
  input  logic              blk_bad,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [WORD_W-1:0] per_rdata,
  output logic [WORD_W-1:0] per_wdata,
  output logic              busy,
  output logic              done_set,
  output logic              err_set
);
  localparam int WCNT_W = LEN_W - 2;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(4);

  eng_state_t        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [1:0]        idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [29:0]       wlen_q, wlen_d;
  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] next_q, next_d;
  logic [WCNT_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] buf_q, buf_d;
  logic              buf_en, blk_end;

  assign busy      = (state_q != ST_IDLE);
  assign mem_wdata = buf_q;
  assign per_wdata = buf_q;
  assign blk_off   = addr_q[PAGE_LG-1:0];
  assign blk_wlen  = wlen_q;

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    idx_d    = idx_q;
    addr_d   = addr_q;
    wlen_d   = wlen_q;
    dir_d    = dir_q;
    next_d   = next_q;
    left_d   = left_q;
    buf_d    = buf_q;
    buf_en   = 1'b0;
    blk_end  = 1'b0;
    mem_addr = '0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    per_ack  = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_go) begin
          if (cfg_chain) begin
            ptr_d   = cfg_base & ALIGN_MASK;
            idx_d   = 2'd0;
            state_d = ST_DESC_RD;
          end else begin
            addr_d  = cfg_base & ALIGN_MASK;
            wlen_d  = cfg_wlen;
            dir_d   = cfg_dir;
            next_d  = '0;
            state_d = ST_CHECK;
          end
        end
      end
      ST_DESC_RD: begin
        mem_rd   = 1'b1;
        mem_addr = ptr_q + ADDR_W'({idx_q, 2'b00});
        state_d  = ST_DESC_CAP;
      end
      ST_DESC_CAP: begin
        idx_d = idx_q + 2'd1;
        unique case (idx_q)
          2'd0:    addr_d = mem_rdata[ADDR_W-1:0] & ALIGN_MASK;
          2'd1:    wlen_d = mem_rdata[WORD_W-1:2];
          2'd2:    dir_d  = mem_rdata[0];
          default: next_d = mem_rdata[ADDR_W-1:0] & ALIGN_MASK;
        endcase
        state_d = (idx_q == 2'd3) ? ST_CHECK : ST_DESC_RD;
      end
      ST_CHECK: begin
        if (blk_bad) begin
          err_set = 1'b1;
          state_d = ST_IDLE;
        end else begin
          left_d  = blk_words;
          state_d = dir_q ? ST_M2D_RD : ST_D2M_WAIT;
        end
      end
      ST_D2M_WAIT: begin
        per_ack = per_req;
        if (per_req) begin
          buf_d   = per_rdata;
          buf_en  = 1'b1;
          state_d = ST_D2M_WR;
        end
      end
      ST_D2M_WR: begin
        mem_wr   = 1'b1;
        mem_addr = addr_q;
        addr_d   = addr_q + STEP;
        left_d   = left_q - WCNT_W'(1);
        if (left_q == WCNT_W'(1)) blk_end = 1'b1;
        else                      state_d = ST_D2M_WAIT;
      end
      ST_M2D_RD: begin
        mem_rd   = 1'b1;
        mem_addr = addr_q;
        state_d  = ST_M2D_CAP;
      end
      ST_M2D_CAP: begin
        buf_d   = mem_rdata;
        buf_en  = 1'b1;
        state_d = ST_M2D_WAIT;
      end
      ST_M2D_WAIT: begin
        per_ack = per_req;
        if (per_req) begin
          addr_d = addr_q + STEP;
          left_d = left_q - WCNT_W'(1);
          if (left_q == WCNT_W'(1)) blk_end = 1'b1;
          else                      state_d = ST_M2D_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (blk_end) begin
      if (next_q != '0) begin
        ptr_d   = next_q;
        idx_d   = 2'd0;
        state_d = ST_DESC_RD;
      end else begin
        done_set = 1'b1;
        state_d  = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      wlen_q  <= '0;
      dir_q   <= 1'b0;
      next_q  <= '0;
      left_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      wlen_q  <= wlen_d;
      dir_q   <= dir_d;
      next_q  <= next_d;
      left_q  <= left_d;
      if (buf_en) buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [31:0]       per_rdata,
  output logic [31:0]       per_wdata,
  output logic              irq
);
  localparam int PAGE_LG = $clog2(PAGE_BYTES);

  logic              rst_sync_n;
  logic              busy_w, done_set, err_set, start_go;
  logic              done_w, err_w, dir_w, chain_w;
  logic [ADDR_W-1:0] base_w;
  logic [31:0]       len_w;
  logic [PAGE_LG-1:0] blk_off;
  logic [29:0]       blk_wlen;
  logic [LEN_W-3:0]  blk_words;
  logic              blk_bad;

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy      (busy_w),
    .done_set  (done_set),
    .err_set   (err_set),
    .base_q    (base_w),
    .len_q     (len_w),
    .dir_q     (dir_w),
    .chain_q   (chain_w),
    .start_go  (start_go),
    .done_q    (done_w),
    .err_q     (err_w)
  );

  dma_page_check #(.LEN_W(LEN_W), .PAGE_LG(PAGE_LG)) u_page (
    .blk_off   (blk_off),
    .blk_wlen  (blk_wlen),
    .blk_words (blk_words),
    .blk_bad   (blk_bad)
  );

  dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_LG(PAGE_LG)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_go  (start_go),
    .cfg_base  (base_w),
    .cfg_wlen  (len_w[31:2]),
    .cfg_dir   (dir_w),
    .cfg_chain (chain_w),
    .blk_off   (blk_off),
    .blk_wlen  (blk_wlen),
    .blk_words (blk_words),
    .blk_bad   (blk_bad),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .per_req   (per_req),
    .per_ack   (per_ack),
    .per_rdata (per_rdata),
    .per_wdata (per_wdata),
    .busy      (busy_w),
    .done_set  (done_set),
    .err_set   (err_set)
  );

  assign irq = done_w;
endmodule

// File: rtl/dma_chain_ctrl_sva.sv
module dma_chain_ctrl_sva
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [1:0]        cmd_bits,
  input logic [1:0]        mem_lsb,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              per_req,
  input logic              per_ack,
  input logic              irq,
  input logic              busy,
  input logic [ADDR_W-1:0] base_q,
  input logic [31:0]       len_q
);
  logic cmd_touch;
  assign cmd_touch = cfg_we && (cfg_addr == REG_CMD) && (cmd_bits != 2'b00);

  AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> per_req); // R3

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_lsb == 2'b00)); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmd_touch) |=> irq); // R7

  AST_IRQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(base_q) && $stable(len_q))); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !per_ack)); // R8
endmodule

bind dma_chain_ctrl dma_chain_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cmd_bits (cfg_wdata[1:0]),
  .mem_lsb  (mem_addr[1:0]),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .per_req  (per_req),
  .per_ack  (per_ack),
  .irq      (irq),
  .busy     (busy_w),
  .base_q   (base_w),
  .len_q    (len_w)
);

// File: tb/test_dma_chain_ctrl.sv
module test_dma_chain_ctrl;
  localparam int ADDR_W = 32;
  localparam int PAGE   = 256;
  localparam logic [31:0] SRC_PAT = 32'hD000_0000;

  // {dir, throttle, addr[11:0], len[15:0]}
  localparam logic [29:0] VEC [6] = '{
    {1'b0, 1'b0, 12'h100, 16'd16},
    {1'b1, 1'b0, 12'h200, 16'd32},
    {1'b0, 1'b1, 12'h3F0, 16'd16},
    {1'b1, 1'b1, 12'h400, 16'd256},
    {1'b0, 1'b0, 12'h504, 16'd7},
    {1'b1, 1'b0, 12'h600, 16'd4}
  };

  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        per_req, per_ack;
  logic [31:0] per_rdata, per_wdata;
  logic        irq;

  logic [31:0] mem [1024];
  logic [31:0] plog [1024];
  logic [31:0] rdq;
  int          hs_cnt;
  int          bus_viol;
  logic        req_en, thr, tgl;
  int          n_chk, n_err;

  dma_chain_ctrl #(.ADDR_W(ADDR_W), .LEN_W(16), .PAGE_BYTES(PAGE)) i_dma_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .per_req(per_req), .per_ack(per_ack),
    .per_rdata(per_rdata), .per_wdata(per_wdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = rdq;
  assign per_rdata = SRC_PAT + 32'(hs_cnt);
  assign per_req   = req_en && (!thr || tgl);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_rd) rdq <= mem[mem_addr[11:2]];
    tgl <= ~tgl;
    if (per_req && per_ack) begin
      plog[hs_cnt[9:0]] <= per_wdata;
      hs_cnt <= hs_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && ((mem_rd && mem_wr) || ((mem_rd || mem_wr) && mem_addr[1:0] != 2'b00)))
      bus_viol <= bus_viol + 1;
  end

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_0101);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit ok;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd(2'd3, s);
      if (!s[0]) begin ok = 1'b1; break; end
    end
    chk({req, " job ends"}, 32'(ok), 32'd1);
  endtask

  task automatic start_job(input logic [31:0] base, input logic [31:0] len, input logic [1:0] mode);
    logic [31:0] s;
    wr(2'd0, base);
    wr(2'd1, len);
    wr(2'd2, {30'd0, mode});
    wr(2'd3, 32'd1);
    rd(2'd3, s);
    chk("R8 busy after start", {31'd0, s[0]}, 32'd1);
  endtask

  task automatic put_desc(input int at, input logic [31:0] a, input logic [31:0] l,
                          input logic [31:0] f, input logic [31:0] n);
    mem[at/4] = a; mem[at/4+1] = l; mem[at/4+2] = f; mem[at/4+3] = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int h0, bad, wd, ba;
    n_chk = 0; n_err = 0; hs_cnt = 0; bus_viol = 0; tgl = 1'b0; rdq = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
    req_en = 1'b0; thr = 1'b0;
    init_mem();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd3, s); chk("R1 status", s, 32'd0);
    rd(2'd0, s); chk("R1 base", s, 32'd0);
    rd(2'd2, s); chk("R1 mode", s, 32'd0);
    chk("R1 irq and strobes", {28'd0, irq, mem_rd, mem_wr, per_ack}, 32'd0);

    // R2 register readback
    wr(2'd0, 32'h0000_0ABC); rd(2'd0, s); chk("R2 base readback", s, 32'h0000_0ABC);
    wr(2'd1, 32'h0000_1234); rd(2'd1, s); chk("R2 len readback", s, 32'h0000_1234);
    wr(2'd2, 32'h0000_0003); rd(2'd2, s); chk("R2 mode readback", s, 32'h0000_0003);

    // table walk: R3 (device to memory), R4 (memory to device), R6 page-end boundary
    for (int v = 0; v < 6; v++) begin
      init_mem();
      thr = VEC[v][28];
      req_en = 1'b1;
      ba = int'(VEC[v][27:16]) / 4;
      wd = int'(VEC[v][15:0]) / 4;
      h0 = hs_cnt;
      start_job({20'd0, VEC[v][27:16]}, {16'd0, VEC[v][15:0]}, {1'b0, VEC[v][29]});
      wait_idle("R3/R4 vector");
      rd(2'd3, s); chk("R7 done set, no error", s, 32'h2);
      chk("R7 irq raised", {31'd0, irq}, 32'd1);
      chk("R3/R4 handshake count", 32'(hs_cnt - h0), 32'(wd));
      bad = 0;
      for (int i = 0; i < wd; i++) begin
        if (VEC[v][29]) begin
          if (plog[h0 + i] !== pat(ba + i) || mem[ba + i] !== pat(ba + i)) bad++;
        end else begin
          if (mem[ba + i] !== SRC_PAT + 32'(h0 + i)) bad++;
        end
      end
      if (mem[ba + wd] !== pat(ba + wd)) bad++;
      chk(VEC[v][29] ? "R4 data order" : "R3 data placement", 32'(bad), 32'd0);
    end
    thr = 1'b0;

    // R7 done is sticky
    repeat (20) @(negedge clk);
    chk("R7 irq held", {31'd0, irq}, 32'd1);
    // R9 clear
    wr(2'd3, 32'h2);
    rd(2'd3, s); chk("R9 clear done", s, 32'd0);
    chk("R9 irq dropped", {31'd0, irq}, 32'd0);

    // R5 chain with mixed directions; LEN and mode dir must not matter
    init_mem();
    put_desc(32'h000, 32'h100, 32'd12, 32'd0, 32'h040);
    put_desc(32'h040, 32'h280, 32'd8,  32'd1, 32'h080);
    put_desc(32'h080, 32'h2F8, 32'd8,  32'd0, 32'h000);
    h0 = hs_cnt;
    start_job(32'h000, 32'd0, 2'b11);
    wait_idle("R5 chain");
    rd(2'd3, s); chk("R5 chain done", s, 32'h2);
    chk("R5 chain handshakes", 32'(hs_cnt - h0), 32'd7);
    bad = 0;
    for (int i = 0; i < 3; i++) if (mem[64 + i] !== SRC_PAT + 32'(h0 + i)) bad++;
    for (int i = 0; i < 2; i++) if (plog[h0 + 3 + i] !== pat(160 + i)) bad++;
    for (int i = 0; i < 2; i++) if (mem[190 + i] !== SRC_PAT + 32'(h0 + 5 + i)) bad++;
    chk("R5 chain data", 32'(bad), 32'd0);

    // R6 second block crosses a page: first block kept, error, no done
    init_mem();
    put_desc(32'h000, 32'h100, 32'd8,  32'd0, 32'h040);
    put_desc(32'h040, 32'h2F8, 32'd16, 32'd0, 32'h000);
    h0 = hs_cnt;
    start_job(32'h000, 32'd0, 2'b10);
    wait_idle("R6 crossing");
    rd(2'd3, s); chk("R6 error without done", s, 32'h4);
    chk("R6 irq stays low", {31'd0, irq}, 32'd0);
    chk("R6 only first block moved", 32'(hs_cnt - h0), 32'd2);
    chk("R6 rejected block untouched", mem[190], pat(190));
    chk("R6 earlier block kept", mem[65], SRC_PAT + 32'(h0 + 1));

    // R6 zero-word direct job
    h0 = hs_cnt;
    start_job(32'h200, 32'd3, 2'b00);
    wait_idle("R6 zero");
    rd(2'd3, s); chk("R6 zero length error", s, 32'h4);
    chk("R6 zero length no handshake", 32'(hs_cnt - h0), 32'd0);

    // R9 accepted start clears error
    start_job(32'h300, 32'd4, 2'b00);
    wait_idle("R9 restart");
    rd(2'd3, s); chk("R9 start clears error", s, 32'h2);

    // R8 writes and start ignored while busy
    init_mem();
    req_en = 1'b0;
    h0 = hs_cnt;
    start_job(32'h100, 32'd8, 2'b00);
    wr(2'd0, 32'h3C0); wr(2'd1, 32'd64); wr(2'd2, 32'd3);
    rd(2'd0, s); chk("R8 base frozen", s, 32'h100);
    rd(2'd1, s); chk("R8 len frozen", s, 32'd8);
    rd(2'd2, s); chk("R8 mode frozen", s, 32'd0);
    wr(2'd3, 32'd1);
    req_en = 1'b1;
    wait_idle("R8 busy job");
    repeat (20) @(negedge clk);
    rd(2'd3, s); chk("R8 second start ignored", s, 32'h2);
    chk("R8 words of first job only", 32'(hs_cnt - h0), 32'd2);

    // R10 bus discipline over the whole run
    chk("R10 strobe overlap or misaligned", 32'(bus_viol), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule